// File: doc/BRIEF.md
# Multi-Owner Hardware Mutex Bank

This block holds a bank of lock slots that a set of command channels and a single CPU requester share. Every requester has its own request port. Each cycle the port can present one operation, acquire or release, together with a slot number. A requester that asks for a free slot gets it. A requester that asks for a slot someone else holds is told to wait. It keeps presenting the acquire until the slot comes free and is handed to it. The block does not stall anything itself: the grant and wait outputs are the only signals a command processor uses to hold its stream.

Every slot publishes a status word. The word carries a flag for "held by a channel", a separate flag for "held by the CPU", and the number of the owning channel. When two or more requesters want the same free slot in the same cycle, the lowest-numbered channel wins and the CPU ranks below every channel. A release only takes effect when the current owner issues it. A release from anyone else changes nothing and raises a per-requester error pulse.

Top module: `mutex_bank`

## Requirements
- R1: After a synchronous reset, every status word reads zero (unlocked) and every grant, wait and error output is low.
- R2: An acquire (operation bit 0) on a free slot whose number is below NUM_SLOTS raises that requester's grant in the following cycle, and the slot's status shows the new owner in that same cycle.
- R3: Status word layout for a slot: bit CH_W+1 means held by a channel, bit CH_W means held by the CPU, and bits CH_W-1:0 carry the owning channel number. The channel-number bits are zero unless a channel holds the slot, and the two flags are never set together.
- R4: An acquire on a slot held by another requester raises that requester's wait in the following cycle. It does not raise grant and it leaves the slot's status unchanged.
- R5: When several requesters acquire the same free slot in one cycle, only the lowest channel number is granted, and the CPU is granted only if no channel asked for that slot.
- R6: A release (operation bit 1) by the current owner frees the slot in the following cycle. Acquires of that slot in the same cycle are not granted and see wait.
- R7: A release from a requester that does not own the slot, including a release of a free slot, leaves the status unchanged and raises that requester's error for one cycle.
- R8: A request whose 8-bit slot number is NUM_SLOTS or larger changes no slot, is neither granted nor made to wait, and raises that requester's error for one cycle.
- R9: An acquire by the current owner of a slot is granted again in the following cycle and leaves the owner unchanged.
- R10: The CPU port obeys the same operation encoding, with 0 meaning acquire and 1 meaning release, and the same 8-bit slot number as the channel ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NUM_CHAN | Per-channel request valid |
| chan_op | input | NUM_CHAN | Per-channel operation: 0 acquire, 1 release |
| chan_idx | input | NUM_CHAN*IDX_W | Per-channel slot number, channel c in bits c*IDX_W +: IDX_W |
| cpu_req | input | 1 | CPU request valid |
| cpu_op | input | 1 | CPU operation: 0 acquire, 1 release |
| cpu_idx | input | IDX_W | CPU slot number |
| chan_grant | output | NUM_CHAN | Registered grant per channel |
| chan_wait | output | NUM_CHAN | Registered wait per channel |
| chan_err | output | NUM_CHAN | Registered error pulse per channel |
| cpu_grant | output | 1 | Registered CPU grant |
| cpu_wait | output | 1 | Registered CPU wait |
| cpu_err | output | 1 | Registered CPU error pulse |
| slot_status | output | NUM_SLOTS*(CH_W+2) | Status words, slot s in bits s*(CH_W+2) +: CH_W+2 |

## Verification
The bench targets three kinds of collision: channels and the CPU racing for one free slot, an owner releasing a slot in the same cycle others try to acquire it, and a stranger releasing a slot that is held or free. A wrong priority encoder would hand the slot to a higher channel or to the CPU. Letting acquires see the release early would grant a slot inside its release cycle. A missing owner check would silently free a slot the releaser never held. Slot numbers beyond the bank are mixed in to catch decoders that alias them onto a real slot. Repeated acquires by an owner are included to catch designs that make an owner wait on itself.

// File: rtl/mutex_bank_pkg.sv
package mutex_bank_pkg;

  typedef enum logic {
    OP_ACQUIRE = 1'b0,
    OP_RELEASE = 1'b1
  } lock_op_e;

  function automatic int id_width(input int nchan);
    return (nchan > 1) ? $clog2(nchan) : 1;
  endfunction

endpackage

// File: rtl/mutex_req_decode.sv
module mutex_req_decode
  import mutex_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 8
) (
  input  logic                 req,
  input  logic                 op,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_SLOTS-1:0] acq_hot,
  output logic [NUM_SLOTS-1:0] rel_hot,
  output logic                 is_acq,
  output logic                 is_rel,
  output logic                 bad_idx
);

  logic in_range;

  assign in_range = (32'(idx) < NUM_SLOTS);
  assign is_acq   = req && in_range && (lock_op_e'(op) == OP_ACQUIRE);
  assign is_rel   = req && in_range && (lock_op_e'(op) == OP_RELEASE);
  assign bad_idx  = req && !in_range;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hot
    assign acq_hot[s] = is_acq && (idx == IDX_W'(s));
    assign rel_hot[s] = is_rel && (idx == IDX_W'(s));
  end

endmodule

// File: rtl/mutex_slot.sv
module mutex_slot #(
  parameter int NUM_REQ = 5,
  parameter int CH_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] acq,
  input  logic [NUM_REQ-1:0] rel,
  output logic [NUM_REQ-1:0] win,
  output logic [NUM_REQ-1:0] rel_ok,
  output logic               st_chan,
  output logic               st_cpu,
  output logic [CH_W-1:0]    st_id
);

  localparam int PW  = $clog2(NUM_REQ);
  localparam int CPU = NUM_REQ - 1;

  logic               free;
  logic [NUM_REQ-1:0] owner_hot;
  logic [PW-1:0]      pick;
  logic               pick_vld;

  assign free = !st_chan && !st_cpu;

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      if (r == CPU) owner_hot[r] = st_cpu;
      else          owner_hot[r] = st_chan && (st_id == CH_W'(r));
    end
  end

  // lowest requester number wins; the CPU sits in the top position
  always_comb begin
    pick     = '0;
    pick_vld = 1'b0;
    for (int r = NUM_REQ - 1; r >= 0; r--) begin
      if (acq[r]) begin
        pick     = PW'(r);
        pick_vld = 1'b1;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      win[r] = free ? (pick_vld && (pick == PW'(r))) : (acq[r] && owner_hot[r]);
    end
  end

  assign rel_ok = rel & owner_hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_chan <= 1'b0;
      st_cpu  <= 1'b0;
      st_id   <= '0;
    end else if (|rel_ok) begin
      st_chan <= 1'b0;
      st_cpu  <= 1'b0;
      st_id   <= '0;
    end else if (free && pick_vld) begin
      if (pick == PW'(CPU)) begin
        st_cpu <= 1'b1;
      end else begin
        st_chan <= 1'b1;
        st_id   <= CH_W'(pick);
      end
    end
  end

  AST_EXCLUSIVE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(st_chan && st_cpu)); // R3
  AST_ID_ZERO_UNLESS_CHAN: assert property (@(posedge clk) disable iff (rst)
    !st_chan |-> (st_id == '0)); // R3
  AST_FREE_ACQ_TAKES: assert property (@(posedge clk) disable iff (rst)
    (free && (|acq)) |=> (st_chan || st_cpu)); // R2
  AST_OWNER_REL_FREES: assert property (@(posedge clk) disable iff (rst)
    (|rel_ok) |=> (!st_chan && !st_cpu)); // R6
  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!free && !(|rel_ok)) |=> $stable({st_chan, st_cpu, st_id})); // R4
  AST_SINGLE_WIN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win)); // R5

endmodule

// File: rtl/mutex_bank.sv
module mutex_bank
  import mutex_bank_pkg::*;
#(
  parameter int NUM_CHAN  = 4,
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 8,
  localparam int CH_W     = id_width(NUM_CHAN),
  localparam int ST_W     = CH_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CHAN-1:0]       chan_req,
  input  logic [NUM_CHAN-1:0]       chan_op,
  input  logic [NUM_CHAN*IDX_W-1:0] chan_idx,
  input  logic                      cpu_req,
  input  logic                      cpu_op,
  input  logic [IDX_W-1:0]          cpu_idx,
  output logic [NUM_CHAN-1:0]       chan_grant,
  output logic [NUM_CHAN-1:0]       chan_wait,
  output logic [NUM_CHAN-1:0]       chan_err,
  output logic                      cpu_grant,
  output logic                      cpu_wait,
  output logic                      cpu_err,
  output logic [NUM_SLOTS*ST_W-1:0] slot_status
);

  localparam int NUM_REQ = NUM_CHAN + 1;

  logic [NUM_REQ-1:0]   req_all;
  logic [NUM_REQ-1:0]   op_all;
  logic [IDX_W-1:0]     idx_all [NUM_REQ];

  logic [NUM_SLOTS-1:0] acq_by_req [NUM_REQ];
  logic [NUM_SLOTS-1:0] rel_by_req [NUM_REQ];
  logic [NUM_REQ-1:0]   is_acq, is_rel, bad_idx;

  logic [NUM_REQ-1:0]   acq_by_slot [NUM_SLOTS];
  logic [NUM_REQ-1:0]   rel_by_slot [NUM_SLOTS];
  logic [NUM_REQ-1:0]   win_by_slot [NUM_SLOTS];
  logic [NUM_REQ-1:0]   ok_by_slot  [NUM_SLOTS];

  logic [NUM_REQ-1:0]   win_any, rel_acc;
  logic [NUM_REQ-1:0]   grant_q, wait_q, err_q;

  always_comb begin
    req_all = {cpu_req, chan_req};
    op_all  = {cpu_op, chan_op};
    for (int r = 0; r < NUM_CHAN; r++) idx_all[r] = chan_idx[r*IDX_W +: IDX_W];
    idx_all[NUM_CHAN] = cpu_idx;
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    mutex_req_decode #(
      .NUM_SLOTS(NUM_SLOTS),
      .IDX_W    (IDX_W)
    ) u_dec (
      .req    (req_all[r]),
      .op     (op_all[r]),
      .idx    (idx_all[r]),
      .acq_hot(acq_by_req[r]),
      .rel_hot(rel_by_req[r]),
      .is_acq (is_acq[r]),
      .is_rel (is_rel[r]),
      .bad_idx(bad_idx[r])
    );
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic            st_chan, st_cpu;
    logic [CH_W-1:0] st_id;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_tr
      assign acq_by_slot[s][r] = acq_by_req[r][s];
      assign rel_by_slot[s][r] = rel_by_req[r][s];
    end

    mutex_slot #(
      .NUM_REQ(NUM_REQ),
      .CH_W   (CH_W)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .acq    (acq_by_slot[s]),
      .rel    (rel_by_slot[s]),
      .win    (win_by_slot[s]),
      .rel_ok (ok_by_slot[s]),
      .st_chan(st_chan),
      .st_cpu (st_cpu),
      .st_id  (st_id)
    );

    assign slot_status[s*ST_W +: ST_W] = {st_chan, st_cpu, st_id};
  end

  always_comb begin
    win_any = '0;
    rel_acc = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      win_any = win_any | win_by_slot[s];
      rel_acc = rel_acc | ok_by_slot[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      wait_q  <= '0;
      err_q   <= '0;
    end else begin
      grant_q <= win_any;
      wait_q  <= is_acq & ~win_any;
      err_q   <= bad_idx | (is_rel & ~rel_acc);
    end
  end

  assign chan_grant = grant_q[NUM_CHAN-1:0];
  assign chan_wait  = wait_q[NUM_CHAN-1:0];
  assign chan_err   = err_q[NUM_CHAN-1:0];
  assign cpu_grant  = grant_q[NUM_CHAN];
  assign cpu_wait   = wait_q[NUM_CHAN];
  assign cpu_err    = err_q[NUM_CHAN];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (slot_status == '0 && grant_q == '0 && wait_q == '0 && err_q == '0)); // R1

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_chk
    AST_GRANT_XOR_WAIT: assert property (@(posedge clk) disable iff (rst)
      !(grant_q[r] && wait_q[r])); // R4
    AST_ERR_EXCLUDES_GRANT: assert property (@(posedge clk) disable iff (rst)
      err_q[r] |-> !grant_q[r]); // R7
    AST_BAD_IDX_FLAGS: assert property (@(posedge clk) disable iff (rst)
      bad_idx[r] |=> (err_q[r] && !wait_q[r])); // R8
  end

endmodule

// File: tb/mutex_bank_test.sv
`timescale 1ns/1ps
module mutex_bank_test;

  localparam int NC   = 3;
  localparam int NS   = 4;
  localparam int IW   = 8;
  localparam int NR   = NC + 1;
  localparam int CW   = 2;
  localparam int SW   = CW + 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NC-1:0]      chan_req = '0;
  logic [NC-1:0]      chan_op  = '0;
  logic [NC*IW-1:0]   chan_idx = '0;
  logic               cpu_req  = 1'b0;
  logic               cpu_op   = 1'b0;
  logic [IW-1:0]      cpu_idx  = '0;
  logic [NC-1:0]      chan_grant, chan_wait, chan_err;
  logic               cpu_grant, cpu_wait, cpu_err;
  logic [NS*SW-1:0]   slot_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  string phase = "R1 reset";

  int own [NS];
  int e_own [NS];
  bit e_g [NR];
  bit e_w [NR];
  bit e_e [NR];

  always #4 clk = ~clk;

  mutex_bank #(.NUM_CHAN(NC), .NUM_SLOTS(NS), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst),
    .chan_req(chan_req), .chan_op(chan_op), .chan_idx(chan_idx),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
    .chan_grant(chan_grant), .chan_wait(chan_wait), .chan_err(chan_err),
    .cpu_grant(cpu_grant), .cpu_wait(cpu_wait), .cpu_err(cpu_err),
    .slot_status(slot_status)
  );

  task automatic set_req(input int r, input bit rq, input bit op, input int idx);
    if (r < NC) begin
      chan_req[r] = rq;
      chan_op[r]  = op;
      chan_idx[r*IW +: IW] = IW'(idx);
    end else begin
      cpu_req = rq;
      cpu_op  = op;
      cpu_idx = IW'(idx);
    end
  endtask

  task automatic clear_reqs();
    for (int r = 0; r < NR; r++) set_req(r, 1'b0, 1'b0, 0);
  endtask

  function automatic bit rd_req(input int r);
    return (r < NC) ? chan_req[r] : cpu_req;
  endfunction
  function automatic bit rd_op(input int r);
    return (r < NC) ? chan_op[r] : cpu_op;
  endfunction
  function automatic int rd_idx(input int r);
    return (r < NC) ? int'(chan_idx[r*IW +: IW]) : int'(cpu_idx);
  endfunction

  function automatic logic [SW-1:0] exp_status(input int o);
    if (o < 0)       return '0;
    else if (o == NC) return SW'(1 << CW);
    else              return SW'((1 << (CW+1)) | o);
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, actual, expected);
    end
  endtask

  // expected effect of the currently driven requests, from the requirements
  task automatic predict();
    bit taken [NS];
    bit freed [NS];
    for (int s = 0; s < NS; s++) begin
      taken[s] = 1'b0; freed[s] = 1'b0; e_own[s] = own[s];
    end
    for (int r = 0; r < NR; r++) begin
      int ix;
      e_g[r] = 1'b0; e_w[r] = 1'b0; e_e[r] = 1'b0;
      ix = rd_idx(r);
      if (rd_req(r)) begin
        if (ix >= NS) e_e[r] = 1'b1;
        else if (rd_op(r) == 1'b0) begin
          if (own[ix] == r) e_g[r] = 1'b1;
          else if (own[ix] < 0 && !taken[ix]) begin
            e_g[r] = 1'b1; taken[ix] = 1'b1; e_own[ix] = r;
          end else e_w[r] = 1'b1;
        end else begin
          if (own[ix] == r) freed[ix] = 1'b1;
          else e_e[r] = 1'b1;
        end
      end
    end
    for (int s = 0; s < NS; s++) if (freed[s]) e_own[s] = -1;
  endtask

  task automatic compare_all();
    for (int r = 0; r < NR; r++) begin
      bit g, w, e;
      g = (r < NC) ? chan_grant[r] : cpu_grant;
      w = (r < NC) ? chan_wait[r]  : cpu_wait;
      e = (r < NC) ? chan_err[r]   : cpu_err;
      check($sformatf("R2/R5/R9 grant req%0d", r), int'(g), int'(e_g[r]));
      check($sformatf("R4/R6 wait req%0d", r), int'(w), int'(e_w[r]));
      check($sformatf("R7/R8/R10 err req%0d", r), int'(e), int'(e_e[r]));
    end
    for (int s = 0; s < NS; s++)
      check($sformatf("R3/R6 status slot%0d", s),
            int'(slot_status[s*SW +: SW]), int'(exp_status(e_own[s])));
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    for (int s = 0; s < NS; s++) own[s] = e_own[s];
    clear_reqs();
  endtask

  initial begin
    for (int s = 0; s < NS; s++) own[s] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 status", int'(slot_status), 0);
    check("R1 grants", int'({cpu_grant, chan_grant}), 0);
    check("R1 waits",  int'({cpu_wait, chan_wait}), 0);
    check("R1 errors", int'({cpu_err, chan_err}), 0);

    phase = "R2 free acquire";
    set_req(1, 1, 0, 2); step();

    phase = "R4 held slot";
    set_req(0, 1, 0, 2); set_req(3, 1, 0, 2); step();

    phase = "R9 owner reacquire";
    set_req(1, 1, 0, 2); step();

    phase = "R5 contention";
    set_req(2, 1, 0, 0); set_req(1, 1, 0, 0); set_req(3, 1, 0, 0); step();
    phase = "R5 cpu below channels";
    set_req(3, 1, 0, 3); set_req(2, 1, 0, 3); step();

    phase = "R7 foreign release";
    set_req(0, 1, 1, 2); set_req(3, 1, 1, 1); step();

    phase = "R6 owner release with racing acquire";
    set_req(1, 1, 1, 2); set_req(0, 1, 0, 2); step();
    phase = "R6 freed slot granted after";
    set_req(0, 1, 0, 2); step();

    phase = "R8 out of range";
    set_req(2, 1, 0, NS); set_req(3, 1, 1, 255); step();

    phase = "R10 cpu acquire and release";
    set_req(3, 1, 0, 1); step();
    set_req(3, 1, 1, 1); step();

    // near-exhaustive sweep: every requester, every slot, both ops, bad numbers
    phase = "sweep";
    begin
      logic [31:0] lf = 32'h1234_5678;
      for (int cyc = 0; cyc < 6000; cyc++) begin
        for (int r = 0; r < NR; r++) begin
          lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
          set_req(r, lf[0] & lf[1], lf[2] & lf[3] & lf[9], int'(lf[10:8]) % 6);
        end
        step();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule